// File: doc/BRIEF.md
# Byte-Stuffing Flag Framer (Encoder and Decoder)

This block turns packets into a self-delimiting byte stream and back again. Its transmit half accepts payload bytes with an end-of-packet marker. It writes an opening flag byte and then the payload. Every payload byte that would be mistaken for a control byte is replaced by an escape pair. A closing flag ends the packet. Its receive half takes a raw byte stream, drops the flags, undoes the escapes and hands out the recovered packets with an end marker on the final byte. A receiver that loses sync finds its place again at the next flag.

Every edge uses a valid/ready handshake. The transmit half is a four-state machine:
- `ENC_IDLE`: presents the opening flag once a payload byte is waiting, and moves to `ENC_BODY` when that flag is taken.
- `ENC_BODY`: forwards plain bytes. It goes to `ENC_ESC2` after sending an escape byte, and to `ENC_CLOSE` after accepting the last byte.
- `ENC_ESC2`: sends the modified byte, then returns to `ENC_BODY`, or goes to `ENC_CLOSE` if that byte was the last.
- `ENC_CLOSE`: sends the closing flag, then goes back to `ENC_IDLE`.

The receive half has two states, `DEC_EMPTY` and `DEC_HOLD`, plus a single escape-pending bit. It keeps one decoded byte back, because only the next byte shows whether that byte ends the packet. When a data byte arrives, `DEC_EMPTY` moves to `DEC_HOLD`. A flag or an abort returns it to `DEC_EMPTY`.

Top module: `hdlc_framer`

## Requirements
- R1: The transmit half emits the flag byte 0x7E before the first payload byte of every packet. Its input ready stays low while that flag is being sent.
- R2: A payload byte other than 0x7E and 0x7D is emitted unchanged, in order.
- R3: A payload byte 0x7E is emitted as 0x7D then 0x5E. A payload byte 0x7D is emitted as 0x7D then 0x5D. In general the second byte of the pair is the payload byte XOR 0x20.
- R4: While the escape byte 0x7D of a pair is emitted, the input ready is low. The payload byte is consumed together with the second byte of the pair.
- R5: After the byte marked last is consumed, the next emitted byte is the closing flag 0x7E.
- R6: While transmit output valid is high and output ready is low, the output byte stays valid and unchanged.
- R7: A flag received while the receive half holds a decoded byte releases that byte with the last marker set. Received data bytes come out in order.
- R8: A received 0x7D is dropped and causes the next non-flag byte to be delivered XORed with 0x20. The escape state then clears, so the byte after it is taken as is.
- R9: A flag received with no decoded byte held, such as back-to-back flags, produces no output.
- R10: A received 0x7D directly followed by 0x7E aborts the packet. The held byte, if any, is delivered with both the last and the error markers set. If no byte was held, nothing is delivered. The error marker is never set without the last marker.
- R11: While receive output valid is high and output ready is low, the output byte and its markers stay unchanged.
- R12: In reset and with no input offered, both output valids are low, transmit input ready is low and receive input ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_pl_valid | input | 1 | Payload byte offered to the transmit half |
| tx_pl_data | input | 8 | Payload byte |
| tx_pl_last | input | 1 | Marks the final payload byte of a packet |
| tx_pl_ready | output | 1 | Transmit half consumes the payload byte |
| tx_ln_valid | output | 1 | Framed byte available on the line side |
| tx_ln_data | output | 8 | Framed byte |
| tx_ln_ready | input | 1 | Line side takes the framed byte |
| rx_ln_valid | input | 1 | Raw line byte offered to the receive half |
| rx_ln_data | input | 8 | Raw line byte |
| rx_ln_ready | output | 1 | Receive half consumes the raw byte |
| rx_pl_valid | output | 1 | Decoded payload byte available |
| rx_pl_data | output | 8 | Decoded payload byte |
| rx_pl_last | output | 1 | Final byte of a recovered packet |
| rx_pl_err | output | 1 | Packet was aborted (set only together with last) |
| rx_pl_ready | input | 1 | Consumer takes the decoded byte |

## Verification
The bench uses the only configuration there is: 8-bit bytes with 0x7E as the flag, 0x7D as the escape and 0x20 as the mask. Because the byte alphabet is this small, one packet can hold all 256 values. That packet is framed and then decoded back under steady and periodically stalled ready. It covers every escaped and unescaped value, both escape pairs, and escapes that fall just before a stall. Short directed streams cover the remaining receive corners: repeated flags, an escaped ordinary byte, an escaped escape byte, an abort with a byte held, and an abort with nothing held.

// File: rtl/hdlc_pkg.sv
package hdlc_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
    localparam logic [BYTE_W-1:0] ESC_BYTE  = 8'h7D;
    localparam logic [BYTE_W-1:0] ESC_MASK  = 8'h20;

    typedef enum logic [1:0] {
        ENC_IDLE,
        ENC_BODY,
        ENC_ESC2,
        ENC_CLOSE
    } enc_state_t;

    typedef enum logic {
        DEC_EMPTY,
        DEC_HOLD
    } dec_state_t;

    function automatic logic is_special(input logic [BYTE_W-1:0] b);
        return (b == FLAG_BYTE) || (b == ESC_BYTE);
    endfunction
endpackage

// File: rtl/hdlc_stuff_enc.sv
module hdlc_stuff_enc
    import hdlc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready
);
    enc_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENC_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENC_IDLE:  if (in_valid && out_ready) state_d = ENC_BODY;
            ENC_BODY: begin
                if (in_valid && out_ready) begin
                    if (is_special(in_data)) state_d = ENC_ESC2;
                    else if (in_last)        state_d = ENC_CLOSE;
                end
            end
            ENC_ESC2:  if (in_valid && out_ready) state_d = in_last ? ENC_CLOSE : ENC_BODY;
            ENC_CLOSE: if (out_ready) state_d = ENC_IDLE;
            default:   state_d = ENC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        out_data  = FLAG_BYTE;
        in_ready  = 1'b0;
        unique case (state_q)
            ENC_IDLE: begin
                out_valid = in_valid;
                out_data  = FLAG_BYTE;
            end
            ENC_BODY: begin
                out_valid = in_valid;
                if (is_special(in_data)) begin
                    out_data = ESC_BYTE;
                end else begin
                    out_data = in_data;
                    in_ready = out_ready;
                end
            end
            ENC_ESC2: begin
                out_valid = in_valid;
                out_data  = in_data ^ ESC_MASK;
                in_ready  = out_ready;
            end
            ENC_CLOSE: begin
                out_valid = 1'b1;
                out_data  = FLAG_BYTE;
            end
            default: ;
        endcase
    end

    AST_ENC_PAIR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && state_q == ENC_BODY && out_data == ESC_BYTE)
        |=> (out_valid && (out_data == 8'h5E || out_data == 8'h5D))); // R3
    AST_ENC_NO_RAW_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && is_special(in_data)) |-> (out_data != in_data)); // R3
    AST_ENC_STALL_ON_ESC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENC_BODY && out_valid && out_data == ESC_BYTE) |-> !in_ready); // R4
    AST_ENC_CLOSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> (out_valid && out_data == FLAG_BYTE)); // R5
    AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
endmodule

// File: rtl/hdlc_stuff_dec.sv
module hdlc_stuff_dec
    import hdlc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    output logic              out_err,
    input  logic              out_ready
);
    dec_state_t        state_q, state_d;
    logic              esc_q, esc_d;
    logic [BYTE_W-1:0] hold_q, hold_d;
    logic              got_flag, esc_start, take;
    logic [BYTE_W-1:0] plain;

    assign got_flag  = (in_data == FLAG_BYTE);
    assign esc_start = !esc_q && (in_data == ESC_BYTE);
    assign plain     = esc_q ? (in_data ^ ESC_MASK) : in_data;
    assign take      = in_valid && in_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DEC_EMPTY;
            esc_q   <= 1'b0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            esc_q   <= esc_d;
            hold_q  <= hold_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        esc_d   = esc_q;
        hold_d  = hold_q;
        if (take) begin
            if (got_flag) begin
                state_d = DEC_EMPTY;
                esc_d   = 1'b0;
            end else if (esc_start) begin
                esc_d   = 1'b1;
            end else begin
                hold_d  = plain;
                state_d = DEC_HOLD;
                esc_d   = 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        out_data  = hold_q;
        out_last  = 1'b0;
        out_err   = 1'b0;
        in_ready  = 1'b1;
        unique case (state_q)
            DEC_EMPTY: ;
            DEC_HOLD: begin
                if (in_valid && !esc_start) begin
                    out_valid = 1'b1;
                    in_ready  = out_ready;
                    if (got_flag) begin
                        out_last = 1'b1;
                        out_err  = esc_q;
                    end
                end
            end
            default: ;
        endcase
    end

    AST_DEC_FLAG_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_data == FLAG_BYTE) |=> !out_valid); // R9
    AST_DEC_ESC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (esc_q && in_valid && in_ready) |=> !esc_q); // R8
    AST_DEC_ERR_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> out_last); // R10
    AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R11
endmodule

// File: rtl/hdlc_framer.sv
module hdlc_framer
    import hdlc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_pl_valid,
    input  logic [BYTE_W-1:0] tx_pl_data,
    input  logic              tx_pl_last,
    output logic              tx_pl_ready,
    output logic              tx_ln_valid,
    output logic [BYTE_W-1:0] tx_ln_data,
    input  logic              tx_ln_ready,
    input  logic              rx_ln_valid,
    input  logic [BYTE_W-1:0] rx_ln_data,
    output logic              rx_ln_ready,
    output logic              rx_pl_valid,
    output logic [BYTE_W-1:0] rx_pl_data,
    output logic              rx_pl_last,
    output logic              rx_pl_err,
    input  logic              rx_pl_ready
);
    hdlc_stuff_enc u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (tx_pl_valid),
        .in_data   (tx_pl_data),
        .in_last   (tx_pl_last),
        .in_ready  (tx_pl_ready),
        .out_valid (tx_ln_valid),
        .out_data  (tx_ln_data),
        .out_ready (tx_ln_ready)
    );

    hdlc_stuff_dec u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_ln_valid),
        .in_data   (rx_ln_data),
        .in_ready  (rx_ln_ready),
        .out_valid (rx_pl_valid),
        .out_data  (rx_pl_data),
        .out_last  (rx_pl_last),
        .out_err   (rx_pl_err),
        .out_ready (rx_pl_ready)
    );

    AST_TOP_OPEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ln_valid && !tx_pl_ready && $past(!tx_ln_valid)) |-> (tx_ln_data == FLAG_BYTE)); // R1
endmodule

// File: tb/hdlc_framer_test.sv
`timescale 1ns/1ps
module hdlc_framer_test;
    typedef logic [7:0] bq_t[$];
    typedef logic [9:0] rq_t[$];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       tx_pl_valid, tx_pl_last, tx_pl_ready, tx_ln_valid, tx_ln_ready;
    logic [7:0] tx_pl_data, tx_ln_data;
    logic       rx_ln_valid, rx_ln_ready, rx_pl_valid, rx_pl_last, rx_pl_err, rx_pl_ready;
    logic [7:0] rx_ln_data, rx_pl_data;

    int n_checks = 0;
    int n_fail = 0;

    hdlc_framer uut (
        .clk(clk), .rst_n(rst_n),
        .tx_pl_valid(tx_pl_valid), .tx_pl_data(tx_pl_data), .tx_pl_last(tx_pl_last),
        .tx_pl_ready(tx_pl_ready), .tx_ln_valid(tx_ln_valid), .tx_ln_data(tx_ln_data),
        .tx_ln_ready(tx_ln_ready), .rx_ln_valid(rx_ln_valid), .rx_ln_data(rx_ln_data),
        .rx_ln_ready(rx_ln_ready), .rx_pl_valid(rx_pl_valid), .rx_pl_data(rx_pl_data),
        .rx_pl_last(rx_pl_last), .rx_pl_err(rx_pl_err), .rx_pl_ready(rx_pl_ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bq_t stuff(input bq_t p);
        bq_t r;
        r.push_back(8'h7E);
        foreach (p[i]) begin
            if (p[i] == 8'h7E || p[i] == 8'h7D) begin
                r.push_back(8'h7D);
                r.push_back(p[i] ^ 8'h20);
            end else begin
                r.push_back(p[i]);
            end
        end
        r.push_back(8'h7E);
        return r;
    endfunction

    function automatic logic [9:0] rec(input logic [7:0] d, input bit last, input bit err);
        return {err, last, d};
    endfunction

    task automatic enc_run(input bq_t pkt, input int stall_mod, output bq_t got);
        int  idx = 0;
        int  cyc = 0;
        bit  done = 0;
        bit  pstall = 0;
        logic [7:0] pdata = 8'h00;
        got = {};
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            tx_pl_valid = (idx < pkt.size());
            tx_pl_data  = (idx < pkt.size()) ? pkt[idx] : 8'h00;
            tx_pl_last  = (idx == pkt.size() - 1);
            tx_ln_ready = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) != 0);
            #1;
            if (pstall)
                check(tx_ln_valid && tx_ln_data == pdata, "R6", "held tx byte", tx_ln_data, pdata);
            pstall = tx_ln_valid && !tx_ln_ready;
            pdata  = tx_ln_data;
            if (tx_ln_valid && tx_ln_ready) begin
                if (got.size() == 0 || tx_ln_data == 8'h7D)
                    check(!tx_pl_ready, (got.size() == 0) ? "R1" : "R4",
                          "payload ready while flag/escape sent", tx_pl_ready, 0);
                got.push_back(tx_ln_data);
                if (tx_ln_data == 8'h7E && got.size() > 1) done = 1;
            end
            if (tx_pl_valid && tx_pl_ready) idx++;
        end
        @(negedge clk);
        tx_pl_valid = 1'b0;
        tx_ln_ready = 1'b1;
    endtask

    task automatic dec_run(input bq_t raw, input int stall_mod, output rq_t got);
        int idx = 0;
        int cyc = 0;
        bit pstall = 0;
        logic [9:0] prec = '0;
        got = {};
        while ((idx < raw.size() || cyc < raw.size() + 3) && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            rx_ln_valid = (idx < raw.size());
            rx_ln_data  = (idx < raw.size()) ? raw[idx] : 8'h00;
            rx_pl_ready = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) != 0);
            #1;
            if (pstall)
                check(rx_pl_valid && {rx_pl_err, rx_pl_last, rx_pl_data} == prec, "R11",
                      "held rx byte", {rx_pl_err, rx_pl_last, rx_pl_data}, prec);
            pstall = rx_pl_valid && !rx_pl_ready;
            prec   = {rx_pl_err, rx_pl_last, rx_pl_data};
            if (rx_pl_valid && rx_pl_ready) got.push_back({rx_pl_err, rx_pl_last, rx_pl_data});
            if (rx_ln_valid && rx_ln_ready) idx++;
        end
        @(negedge clk);
        rx_ln_valid = 1'b0;
        rx_pl_ready = 1'b1;
    endtask

    task automatic cmp_bytes(input bq_t got, input bq_t exp, input string req);
        check(got.size() == exp.size(), req, "byte count", got.size(), exp.size());
        foreach (exp[i])
            if (i < got.size()) check(got[i] == exp[i], req, $sformatf("byte %0d", i), got[i], exp[i]);
    endtask

    task automatic cmp_recs(input rq_t got, input rq_t exp, input string req);
        check(got.size() == exp.size(), req, "record count", got.size(), exp.size());
        foreach (exp[i])
            if (i < got.size()) check(got[i] == exp[i], req, $sformatf("record %0d", i), got[i], exp[i]);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        bq_t all_b, enc_got, raw, one, ex;
        rq_t drec, dex;
        tx_pl_valid = 0; tx_pl_data = 0; tx_pl_last = 0; tx_ln_ready = 1;
        rx_ln_valid = 0; rx_ln_data = 0; rx_pl_ready = 1;

        // R12: reset state
        repeat (3) @(negedge clk);
        #1;
        check(!tx_ln_valid && !rx_pl_valid, "R12", "valids in reset", {tx_ln_valid, rx_pl_valid}, 0);
        check(!tx_pl_ready && rx_ln_ready, "R12", "readies in reset", {tx_pl_ready, rx_ln_ready}, 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!tx_ln_valid && !rx_pl_valid, "R12", "valids after reset", {tx_ln_valid, rx_pl_valid}, 0);

        for (int v = 0; v < 256; v++) all_b.push_back(v[7:0]);
        ex = stuff(all_b);

        // R1 R2 R3 R5: full byte sweep, no stall and with stalls
        for (int m = 0; m < 3; m++) begin
            enc_run(all_b, (m == 0) ? 0 : m + 2, enc_got);
            cmp_bytes(enc_got, ex, "R2_R3");
            check(enc_got.size() > 0 && enc_got[0] == 8'h7E, "R1", "opening flag",
                  (enc_got.size() > 0) ? enc_got[0] : 0, 8'h7E);
            check(enc_got.size() > 0 && enc_got[enc_got.size()-1] == 8'h7E, "R5", "closing flag",
                  (enc_got.size() > 0) ? enc_got[enc_got.size()-1] : 0, 8'h7E);
        end

        // R3 R5: single-byte packets
        for (int k = 0; k < 4; k++) begin
            one = {};
            case (k)
                0: one.push_back(8'h7E);
                1: one.push_back(8'h7D);
                2: one.push_back(8'h41);
                default: one.push_back(8'h5E);
            endcase
            enc_run(one, 2, enc_got);
            cmp_bytes(enc_got, stuff(one), "R3_R5");
        end

        // R7 R8: loopback of the full sweep into the receive half
        dex = {};
        foreach (all_b[i]) dex.push_back(rec(all_b[i], i == 255, 0));
        dec_run(ex, 0, drec);
        cmp_recs(drec, dex, "R7_R8");
        dec_run(ex, 4, drec);
        cmp_recs(drec, dex, "R7_R8_R11");

        // R9: two stuffed packets back to back, plus extra flags
        raw = {};
        one = stuff('{8'h7E, 8'h01});
        foreach (one[i]) raw.push_back(one[i]);
        raw.push_back(8'h7E);
        one = stuff('{8'h7D});
        foreach (one[i]) raw.push_back(one[i]);
        dex = '{rec(8'h7E, 0, 0), rec(8'h01, 1, 0), rec(8'h7D, 1, 0)};
        dec_run(raw, 3, drec);
        cmp_recs(drec, dex, "R9");

        dec_run('{8'h7E, 8'h7E, 8'h7E}, 0, drec);
        check(drec.size() == 0, "R9", "flags only", drec.size(), 0);

        // R8: escaped ordinary byte and escaped escape byte
        dec_run('{8'h7E, 8'h7D, 8'h61, 8'h62, 8'h7E}, 0, drec);
        cmp_recs(drec, '{rec(8'h41, 0, 0), rec(8'h62, 1, 0)}, "R8");
        dec_run('{8'h7E, 8'h7D, 8'h7D, 8'h7E}, 0, drec);
        cmp_recs(drec, '{rec(8'h5D, 1, 0)}, "R8");

        // R10: abort with a held byte, then a clean packet
        dec_run('{8'h7E, 8'h11, 8'h22, 8'h7D, 8'h7E, 8'h33, 8'h7E}, 2, drec);
        cmp_recs(drec, '{rec(8'h11, 0, 0), rec(8'h22, 1, 1), rec(8'h33, 1, 0)}, "R10");
        // R10: abort with nothing held, escape state cleared afterwards
        dec_run('{8'h7E, 8'h7D, 8'h7E, 8'h44, 8'h7E}, 0, drec);
        cmp_recs(drec, '{rec(8'h44, 1, 0)}, "R10");

        summary();
        $finish;
    end
endmodule